// File: doc/BRIEF.md
# Triggered Transfer Group Sequencer

This block drives a serial shift engine from a shared buffer memory of 128 entries. Each entry carries four 16-bit words: a transmit word, a control (format) word, a received word and a status word. Up to eight transfer groups divide the memory into contiguous ranges. Each group is started by a hardware trigger and not by software.

Each group picks one of fifteen trigger inputs and reacts either to a rising edge or to a sustained low level on it. Trigger inputs pass through a two-flop synchroniser before they are used. When a group is triggered and the sequencer is free, the sequencer walks the group's entries in ascending order. For each entry it issues one request to the engine with that entry's transmit and control words. When the engine reports completion, the sequencer stores the received word and marks the status word valid, or valid and overrun if the previous data was never read. When several groups are waiting, the lowest-numbered one goes first, and a running group always finishes before another starts. After a group's final entry the sequencer gives a one-cycle completion pulse and sets a sticky flag for that group.

A simple port loads transmit and control words. A second port reads received and status words, and a read clears the entry's status.

Top module: `tgs_sequencer`

## Requirements
- R1: Group g serves the entries from its start index (grp_start[7g+6:7g]) up to one below the start index of the next higher-numbered enabled group, or up to entry 127 when there is none. Entries are served in ascending order. Start indices of disabled groups play no part.
- R2: A rising-edge group (grp_level[g]=0) runs exactly once per rising edge of its selected input. If the input changes before clock edge k, eng_req is first high after edge k+3. Holding the input high does not start the group again.
- R3: A level group (grp_level[g]=1) starts while its selected input is low. If the input falls before clock edge k, eng_req is first high after edge k+2. The group reruns back to back for as long as the input stays low.
- R4: The 4-bit source field grp_src[4g+3:4g] selects trig_in bit 0 to 14. The value 15 selects no input, so the group never starts. A group reacts to no input other than the one it selects.
- R5: When the sequencer is idle, the lowest-numbered pending group starts first, whatever order the triggers arrived in. A running group is never pre-empted.
- R6: For each entry, eng_req is high for exactly one cycle and carries that entry's transmit word on eng_tx and control word on eng_ctrl. The request for the next entry comes in the cycle right after the previous eng_done.
- R7: On eng_done the entry's receive word becomes eng_rx. Its status word becomes bit0 (valid) = 1 and bit1 (overrun) = 1 if bit0 or bit1 was already set, else 0. All other status bits are 0.
- R8: rd_rx and rd_stat show entry rd_idx combinationally. rd_en clears that entry's status at the clock edge and leaves its receive word unchanged. A write-back to the same entry in the same cycle takes precedence.
- R9: grp_done[g] pulses for one cycle in the cycle after the group's final eng_done, and grp_flag[g] is set at the same time. The flag stays set until flag_clr[g] is high at a clock edge.
- R10: A disabled group (grp_en[g]=0) never runs, and a pending edge trigger is dropped while the group is disabled.
- R11: After reset no request is issued, all completion pulses and flags are 0, and all receive and status words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 15 | Asynchronous trigger inputs |
| grp_en | input | 8 | Per-group enable |
| grp_level | input | 8 | Per-group trigger type: 1 = low level, 0 = rising edge |
| grp_src | input | 32 | Per-group 4-bit trigger source select |
| grp_start | input | 56 | Per-group 7-bit start index |
| flag_clr | input | 8 | Clears the matching sticky completion flags |
| wr_en | input | 1 | Load transmit and control words |
| wr_idx | input | 7 | Entry to load |
| wr_tx | input | 16 | Transmit word to load |
| wr_ctrl | input | 16 | Control word to load |
| rd_en | input | 1 | Read strobe; clears the entry's status |
| rd_idx | input | 7 | Entry to read |
| rd_rx | output | 16 | Received word of entry rd_idx |
| rd_stat | output | 16 | Status word of entry rd_idx |
| eng_req | output | 1 | One-cycle request to the shift engine |
| eng_tx | output | 16 | Transmit word for the request |
| eng_ctrl | output | 16 | Control word for the request |
| eng_done | input | 1 | Engine completion pulse |
| eng_rx | input | 16 | Received word, valid with eng_done |
| grp_done | output | 8 | Per-group completion pulse |
| grp_flag | output | 8 | Per-group sticky completion flag |

## Verification
The sequencer is driven with four trigger patterns. A single edge that is held high tells one run apart from repeated runs. A held low level has to produce whole back-to-back passes over the same range. Edges on two groups while a long third group is running, with the higher-numbered group triggered first, separate lowest-number priority from arrival order and show that the running group is not pre-empted. Triggers on a disabled group and on an input that no group selects must produce no request at all. Reading entries that were written once and entries that were written twice tells the valid status from the overrun status, and the group ranges are set so that a one-entry group, a range that stretches past a disabled group and a range that ends at entry 127 are all covered.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  localparam int WORD_W = 16;
  localparam int ST_VALID = 0;
  localparam int ST_OVR   = 1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_state_t;

  // Status written back after a buffer completes.
  function automatic logic [WORD_W-1:0] wb_status(input logic [WORD_W-1:0] old);
    logic [WORD_W-1:0] s;
    s = '0;
    s[ST_VALID] = 1'b1;
    s[ST_OVR]   = old[ST_VALID] | old[ST_OVR];
    return s;
  endfunction
endpackage

// File: rtl/tgs_trig_sync.sv
module tgs_trig_sync #(
  parameter int NSRC  = 15,
  parameter int NGRP  = 8,
  parameter int SRC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         trig_in,
  input  logic [NGRP-1:0]         grp_en,
  input  logic [NGRP-1:0]         grp_level,
  input  logic [NGRP*SRC_W-1:0]   grp_src,
  input  logic [NGRP-1:0]         pend_clr,
  output logic [NGRP-1:0]         pend
);
  localparam int SEL_N = 1 << SRC_W;
  localparam int PAD   = SEL_N - NSRC;

  logic [NSRC-1:0]  s1, s2, s3;
  logic [SEL_N-1:0] now_pad, prv_pad;
  logic [NGRP-1:0]  rise_v, low_v, edge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= trig_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // unused select codes read as idle-high, so they never trigger
  assign now_pad = {{PAD{1'b1}}, s2};
  assign prv_pad = {{PAD{1'b1}}, s3};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [SRC_W-1:0] sel;
    assign sel       = grp_src[g*SRC_W +: SRC_W];
    assign rise_v[g] = grp_en[g] & ~grp_level[g] & now_pad[sel] & ~prv_pad[sel];
    assign low_v[g]  = grp_en[g] &  grp_level[g] & ~now_pad[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= '0;
    else        edge_q <= ((edge_q & ~pend_clr) | rise_v) & grp_en;
  end

  assign pend = edge_q | low_v;
endmodule

// File: rtl/tgs_arbiter.sv
module tgs_arbiter #(
  parameter int NGRP  = 8,
  parameter int GRP_W = 3
) (
  input  logic [NGRP-1:0]  pend,
  output logic             any,
  output logic [GRP_W-1:0] win
);
  always_comb begin
    win = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (pend[g]) win = GRP_W'(g);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/tgs_bufmem.sv
module tgs_bufmem
  import tgs_pkg::*;
#(
  parameter int NENT  = 128,
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_tx,
  input  logic [WORD_W-1:0] wr_ctrl,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_rx,
  output logic [WORD_W-1:0] rd_stat,
  input  logic [IDX_W-1:0]  eng_idx,
  output logic [WORD_W-1:0] eng_tx,
  output logic [WORD_W-1:0] eng_ctrl,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [WORD_W-1:0] wb_rx
);
  logic [WORD_W-1:0] tx_m   [NENT];
  logic [WORD_W-1:0] ctrl_m [NENT];
  logic [WORD_W-1:0] rx_m   [NENT];
  logic [WORD_W-1:0] st_m   [NENT];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tx_m[wr_idx]   <= wr_tx;
      ctrl_m[wr_idx] <= wr_ctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        rx_m[i] <= '0;
        st_m[i] <= '0;
      end
    end else begin
      if (rd_en) st_m[rd_idx] <= '0;
      if (wb_en) begin
        rx_m[wb_idx] <= wb_rx;
        st_m[wb_idx] <= wb_status(st_m[wb_idx]);
      end
    end
  end

  assign rd_rx    = rx_m[rd_idx];
  assign rd_stat  = st_m[rd_idx];
  assign eng_tx   = tx_m[eng_idx];
  assign eng_ctrl = ctrl_m[eng_idx];
endmodule

// File: rtl/tgs_sequencer.sv
module tgs_sequencer
  import tgs_pkg::*;
#(
  parameter int NENT = 128,
  parameter int NGRP = 8,
  parameter int NSRC = 15,
  localparam int IDX_W = $clog2(NENT),
  localparam int SRC_W = $clog2(NSRC + 1),
  localparam int GRP_W = $clog2(NGRP)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         trig_in,
  input  logic [NGRP-1:0]         grp_en,
  input  logic [NGRP-1:0]         grp_level,
  input  logic [NGRP*SRC_W-1:0]   grp_src,
  input  logic [NGRP*IDX_W-1:0]   grp_start,
  input  logic [NGRP-1:0]         flag_clr,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wr_tx,
  input  logic [WORD_W-1:0]       wr_ctrl,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [WORD_W-1:0]       rd_rx,
  output logic [WORD_W-1:0]       rd_stat,
  output logic                    eng_req,
  output logic [WORD_W-1:0]       eng_tx,
  output logic [WORD_W-1:0]       eng_ctrl,
  input  logic                    eng_done,
  input  logic [WORD_W-1:0]       eng_rx,
  output logic [NGRP-1:0]         grp_done,
  output logic [NGRP-1:0]         grp_flag
);
  sq_state_t        state;
  logic [GRP_W-1:0] cur_grp, start_grp;
  logic [IDX_W-1:0] cur_idx, cur_start, cur_end;
  logic [NGRP-1:0]  pend, pend_clr, fin_vec, done_q, flag_q;
  logic             any_pend, start_fire, wb_fire, last_fire, busy;

  // Last entry of group g: one below the next higher enabled start, else the top entry.
  function automatic logic [IDX_W-1:0] range_end(input logic [GRP_W-1:0] g,
                                                 input logic [NGRP-1:0] en,
                                                 input logic [NGRP*IDX_W-1:0] st);
    logic [IDX_W-1:0] e;
    e = IDX_W'(NENT - 1);
    for (int h = NGRP - 1; h >= 0; h--) begin
      if (h > int'(g) && en[h]) e = st[h*IDX_W +: IDX_W] - IDX_W'(1);
    end
    return e;
  endfunction

  tgs_trig_sync #(.NSRC(NSRC), .NGRP(NGRP), .SRC_W(SRC_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .grp_en(grp_en),
    .grp_level(grp_level), .grp_src(grp_src), .pend_clr(pend_clr), .pend(pend)
  );

  tgs_arbiter #(.NGRP(NGRP), .GRP_W(GRP_W)) u_arb (
    .pend(pend), .any(any_pend), .win(start_grp)
  );

  tgs_bufmem #(.NENT(NENT), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tx(wr_tx), .wr_ctrl(wr_ctrl),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_rx(rd_rx), .rd_stat(rd_stat),
    .eng_idx(cur_idx), .eng_tx(eng_tx), .eng_ctrl(eng_ctrl),
    .wb_en(wb_fire), .wb_idx(cur_idx), .wb_rx(eng_rx)
  );

  assign cur_start  = grp_start[cur_grp*IDX_W +: IDX_W];
  assign cur_end    = range_end(cur_grp, grp_en, grp_start);
  assign busy       = (state != SQ_IDLE);
  assign start_fire = (state == SQ_IDLE) && any_pend;
  assign wb_fire    = (state == SQ_WAIT) && eng_done;
  assign last_fire  = wb_fire && (cur_idx == cur_end);
  assign eng_req    = (state == SQ_ISSUE);

  always_comb begin
    pend_clr = '0;
    if (start_fire) pend_clr[start_grp] = 1'b1;
  end

  always_comb begin
    fin_vec = '0;
    if (last_fire) fin_vec[cur_grp] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cur_grp <= '0;
      cur_idx <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (any_pend) begin
          cur_grp <= start_grp;
          cur_idx <= grp_start[start_grp*IDX_W +: IDX_W];
          state   <= SQ_ISSUE;
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: if (eng_done) begin
          if (last_fire) begin
            state <= SQ_IDLE;
          end else begin
            cur_idx <= cur_idx + IDX_W'(1);
            state   <= SQ_ISSUE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      flag_q <= '0;
    end else begin
      done_q <= fin_vec;
      flag_q <= (flag_q & ~flag_clr) | fin_vec;
    end
  end

  assign grp_done = done_q;
  assign grp_flag = flag_q;
endmodule

// File: rtl/tgs_sequencer_chk.sv
module tgs_sequencer_chk #(
  parameter int NGRP  = 8,
  parameter int GRP_W = 3,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_req,
  input logic             busy,
  input logic [GRP_W-1:0] cur_grp,
  input logic [IDX_W-1:0] cur_idx,
  input logic [IDX_W-1:0] cur_start,
  input logic [IDX_W-1:0] cur_end,
  input logic [NGRP-1:0]  grp_done,
  input logic [NGRP-1:0]  grp_flag,
  input logic             start_fire,
  input logic [GRP_W-1:0] start_grp,
  input logic [NGRP-1:0]  grp_en,
  input logic             wb_fire
);
  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  // R6
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> busy);

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_idx >= cur_start && cur_idx <= cur_end));

  // R5
  grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_grp));

  // R10
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |-> grp_en[start_grp]);

  // R9
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_done));

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_done) |-> ((grp_done & grp_flag) == grp_done));

  // R9
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_done) |-> $past(wb_fire));
endmodule

bind tgs_sequencer tgs_sequencer_chk #(.NGRP(NGRP), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .busy(busy), .cur_grp(cur_grp),
  .cur_idx(cur_idx), .cur_start(cur_start), .cur_end(cur_end), .grp_done(grp_done),
  .grp_flag(grp_flag), .start_fire(start_fire), .start_grp(start_grp),
  .grp_en(grp_en), .wb_fire(wb_fire)
);

// File: tb/tgs_sequencer_test.sv
module tgs_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] trig_in = 15'h0004;
  logic [7:0]  grp_en, grp_level, flag_clr;
  logic [31:0] grp_src;
  logic [55:0] grp_start;
  logic        wr_en = 1'b0, rd_en = 1'b0, eng_done = 1'b0;
  logic [6:0]  wr_idx = '0, rd_idx = '0;
  logic [15:0] wr_tx = '0, wr_ctrl = '0, eng_rx = '0;
  logic [15:0] rd_rx, rd_stat, eng_tx, eng_ctrl;
  logic        eng_req;
  logic [7:0]  grp_done, grp_flag;

  int errors = 0, checks = 0;
  bit finished = 0, m_on = 0;
  int log_q[$];
  int lat = 2, cnt = 0;
  logic [15:0] lat_tx;

  always #5 clk = ~clk;

  tgs_sequencer uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .grp_en(grp_en), .grp_level(grp_level),
    .grp_src(grp_src), .grp_start(grp_start), .flag_clr(flag_clr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tx(wr_tx), .wr_ctrl(wr_ctrl),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_rx(rd_rx), .rd_stat(rd_stat),
    .eng_req(eng_req), .eng_tx(eng_tx), .eng_ctrl(eng_ctrl),
    .eng_done(eng_done), .eng_rx(eng_rx), .grp_done(grp_done), .grp_flag(grp_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int b_src(input int g);
    return int'(grp_src[g*4 +: 4]);
  endfunction
  function automatic int b_start(input int g);
    return int'(grp_start[g*7 +: 7]);
  endfunction
  function automatic int b_end(input int g);
    for (int h = g + 1; h < 8; h++) if (grp_en[h]) return b_start(h) - 1;
    return 127;
  endfunction

  // Shift engine stand-in: answers each request after lat cycles with the inverted word.
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        eng_done = 1'b1;
        eng_rx = ~lat_tx;
      end
    end
    if (rst_n && eng_req) begin
      lat_tx = eng_tx;
      cnt = lat;
      log_q.push_back(int'(eng_tx) - 'h1000);
    end
  end

  // Reference model, advanced on each rising clock edge.
  int m_st, m_grp, m_idx;
  bit [14:0] ms1, ms2, ms3;
  bit [7:0] m_pend, m_done, m_flag, pv, setv, clrv, fin;
  int m_tx[128], m_ctrl[128];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pend = '0; m_done = '0; m_flag = '0;
      ms1 = '1; ms2 = '1; ms3 = '1;
    end else begin
      pv = m_pend; setv = '0; clrv = '0; fin = '0;
      for (int g = 0; g < 8; g++) begin
        int s;
        s = b_src(g);
        if (s < 15 && grp_en[g] && grp_level[g] && !ms2[s]) pv[g] = 1'b1;
        if (s < 15 && grp_en[g] && !grp_level[g] && ms2[s] && !ms3[s]) setv[g] = 1'b1;
      end
      if (m_st == 0) begin
        for (int g = 7; g >= 0; g--) if (pv[g]) m_grp = g;
        if (pv != 0) begin
          clrv[m_grp] = 1'b1;
          m_idx = b_start(m_grp);
          m_st = 1;
        end
      end else if (m_st == 1) begin
        m_st = 2;
      end else if (eng_done) begin
        if (m_idx == b_end(m_grp)) begin
          fin[m_grp] = 1'b1;
          m_st = 0;
        end else begin
          m_idx++;
          m_st = 1;
        end
      end
      m_pend = ((m_pend & ~clrv) | setv) & grp_en;
      m_flag = (m_flag & ~flag_clr) | fin;
      m_done = fin;
      ms3 = ms2; ms2 = ms1; ms1 = trig_in;
      if (wr_en) begin
        m_tx[wr_idx] = int'(wr_tx);
        m_ctrl[wr_idx] = int'(wr_ctrl);
      end
    end
  end

  always @(negedge clk) begin
    if (m_on) begin
      check(eng_req == (m_st == 1), "R6", "request", int'(eng_req), int'(m_st == 1));
      if (m_st == 1 && eng_req) begin
        check(int'(eng_tx) == m_tx[m_idx], "R6", "tx word", int'(eng_tx), m_tx[m_idx]);
        check(int'(eng_ctrl) == m_ctrl[m_idx], "R6", "ctrl word", int'(eng_ctrl), m_ctrl[m_idx]);
      end
      check(grp_done == m_done, "R9", "done pulses", int'(grp_done), int'(m_done));
      check(grp_flag == m_flag, "R9", "sticky flags", int'(grp_flag), int'(m_flag));
    end
  end

  task automatic wait_done(input int g);
    int n = 0;
    do begin @(negedge clk); n++; end while (!grp_done[g] && n < 5000);
    check(grp_done[g] == 1'b1, "R9", "completion pulse seen", int'(grp_done[g]), 1);
  endtask

  task automatic check_log(input string req, input int first, input int last, input int off);
    for (int k = 0; k <= last - first; k++) begin
      int v;
      v = (off + k < log_q.size()) ? log_q[off + k] : -1;
      check(v == first + k, req, "entry order", v, first + k);
    end
  endtask

  task automatic start_delay(input int bitn, input bit val, output int n);
    @(negedge clk);
    trig_in[bitn] = val;
    n = 0;
    do begin @(negedge clk); n++; end while (!eng_req && n < 20);
  endtask

  initial begin
    int n;
    grp_en    = 8'b1101_0111;
    grp_level = 8'b0000_0100;
    flag_clr  = '0;
    grp_src   = {4'd7, 4'd15, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0};
    grp_start = {7'd124, 7'd120, 7'd60, 7'd10, 7'd6, 7'd4, 7'd3, 7'd0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_on = 1;
    @(negedge clk);
    // R11 reset state
    check(eng_req == 1'b0, "R11", "no request", int'(eng_req), 0);
    check(grp_flag == 8'h00, "R11", "flags clear", int'(grp_flag), 0);
    check(grp_done == 8'h00, "R11", "pulses clear", int'(grp_done), 0);
    rd_idx = 7'd5;
    #1;
    check(rd_stat == 16'h0 && rd_rx == 16'h0, "R11", "entry cleared", int'(rd_stat), 0);

    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 7'(i);
      wr_tx = 16'h1000 + 16'(i); wr_ctrl = 16'h2000 + 16'(i);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R2 single edge, held high
    log_q.delete();
    start_delay(0, 1'b1, n);
    check(n == 4, "R2", "edge start latency", n, 4);
    wait_done(0);
    repeat (20) @(negedge clk);
    check(log_q.size() == 3, "R2", "one run per edge", log_q.size(), 3);
    check_log("R1", 0, 2, 0);
    check(grp_flag[0] == 1'b1, "R9", "flag after run", int'(grp_flag[0]), 1);
    trig_in[0] = 1'b0;

    // R3 level low, repeated runs over 4..9 (group 3 disabled)
    log_q.delete();
    start_delay(2, 1'b0, n);
    check(n == 3, "R3", "level start latency", n, 3);
    wait_done(2);
    wait_done(2);
    trig_in[2] = 1'b1;
    repeat (60) @(negedge clk);
    check(log_q.size() >= 12 && log_q.size() % 6 == 0, "R3", "whole repeated runs",
          log_q.size(), 12);
    for (int k = 0; k < log_q.size(); k++)
      check(log_q[k] == 4 + k % 6, "R1", "level group order", log_q[k], 4 + k % 6);

    // R5 priority: group 4 runs, group 1 then group 0 triggered meanwhile
    log_q.delete();
    @(negedge clk); trig_in[4] = 1'b1;
    repeat (6) @(negedge clk); trig_in[4] = 1'b0;
    repeat (30) @(negedge clk); trig_in[1] = 1'b1;
    repeat (6) @(negedge clk); trig_in[1] = 1'b0;
    repeat (3) @(negedge clk); trig_in[0] = 1'b1;
    repeat (6) @(negedge clk); trig_in[0] = 1'b0;
    wait_done(1);
    repeat (5) @(negedge clk);
    check(log_q.size() == 114, "R5", "request count", log_q.size(), 114);
    check_log("R5", 10, 119, 0);
    check_log("R5", 0, 2, 110);
    check_log("R5", 3, 3, 113);

    // R7 write-back, R8 host read
    @(negedge clk);
    rd_idx = 7'd3;
    #1;
    check(rd_stat == 16'h0001, "R7", "valid only", int'(rd_stat), 1);
    check(rd_rx == ~16'h1003, "R7", "received word", int'(rd_rx), int'(~16'h1003));
    rd_idx = 7'd0;
    #1;
    check(rd_stat == 16'h0003, "R7", "overrun", int'(rd_stat), 3);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    check(rd_stat == 16'h0000, "R8", "read clears status", int'(rd_stat), 0);
    check(rd_rx == ~16'h1000, "R8", "read keeps data", int'(rd_rx), int'(~16'h1000));

    // R10 disabled group, R4 unselected input
    log_q.delete();
    @(negedge clk); trig_in[3] = 1'b1; trig_in[6] = 1'b1;
    repeat (6) @(negedge clk); trig_in[3] = 1'b0; trig_in[6] = 1'b0;
    repeat (20) @(negedge clk);
    check(log_q.size() == 0, "R10", "no run from disabled group", log_q.size(), 0);
    check(grp_flag[3] == 1'b0, "R10", "disabled flag", int'(grp_flag[3]), 0);
    check(grp_flag[6] == 1'b0, "R4", "source 15 never runs", int'(grp_flag[6]), 0);

    // R9 flag clear
    @(negedge clk);
    flag_clr = 8'h01;
    @(negedge clk);
    flag_clr = 8'h00;
    check(grp_flag[0] == 1'b0, "R9", "flag cleared", int'(grp_flag[0]), 0);
    check(grp_flag[1] == 1'b1, "R9", "other flag kept", int'(grp_flag[1]), 1);

    // R1 last group ends at entry 127
    log_q.delete();
    @(negedge clk); trig_in[7] = 1'b1;
    repeat (6) @(negedge clk); trig_in[7] = 1'b0;
    wait_done(7);
    repeat (5) @(negedge clk);
    check(log_q.size() == 4, "R1", "top group size", log_q.size(), 4);
    check_log("R1", 124, 127, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule